// File: doc/BRIEF.md
# Timer Trigger Output Generator

This block is an up-counting timer whose main product is one trigger line that a second timer can follow. A prescaler divides the clock, and a counter runs from zero to a programmable reload value. Four channels compare the count against their own thresholds and drive reference waveforms. Channel 1 can instead capture the count when a rising edge arrives on its input. That input is either one pin or the XOR of three pins.

A 3-bit source field picks what drives the trigger line. The choices are the software update request, the internal run enable, the update event, a channel 1 event pulse, or one of the four compare waveforms. Each channel also raises a one-cycle DMA request. A select bit sets whether the request follows the channel's own event or the update event. All configuration arrives on plain input ports. The output pulses are registered and one clock wide.

Top module: `tmr_trig_gen`

## Requirements
- R1: While the run enable is high, the prescaler counts enabled cycles from 0 to `psc_div`. On the cycle it equals `psc_div`, it returns to 0 and the counter steps once. The counter goes 0, 1, … up to `arr` and then back to 0. The step to 0 after `arr` gives a one-cycle `upd_evt` in the cycle after that clock edge.
- R2: A high `upd_gen` clears the counter and the prescaler at the next edge and raises `upd_evt` for one cycle. This takes priority over counting.
- R3: The run enable is `cnt_en_bit | (gated_mode & ext_trig)`. While it is low and `upd_gen` is low, the counter and prescaler hold their values.
- R4: `oc_ref[k]` is high exactly while `cnt_q` is below the compare value of channel k. The compare value of channel k sits in `cmp_val[k*CNT_W +: CNT_W]`.
- R5: A compare event `cc_evt[k]` is a one-cycle pulse. It occurs after every counter step (count, wrap or update request) that gives the counter a value equal to channel k's compare value. `cc1_flag` is set by every channel 1 event. It is cleared by `cc1_flag_clr`, but a simultaneous event wins.
- R6: With `ch1_capture` high, channel 1 stops producing compare events. Instead it produces an event on each rising edge of its input after a SYNC_N-flop synchroniser. The event appears SYNC_N+1 edges after the input changes, and the count held before that last edge is loaded into `cc1_capt`.
- R7: With `ti_xor_sel` at 0, the channel 1 input is `ch_pin[0]`. With it at 1, the input is `ch_pin[0]^ch_pin[1]^ch_pin[2]`.
- R8: With `dma_on_upd` at 0, `dma_req[k]` equals `cc_evt[k]`. With it at 1, every bit of `dma_req` equals `upd_evt`.
- R9: Source codes 000, 001 and 010 set `trig_out` as follows. Code 000 gives `upd_gen` delayed one clock. Code 001 gives the run enable delayed one clock. Code 010 gives a copy of `upd_evt`.
- R10: Source code 011 makes `trig_out` a copy of `cc_evt[0]`. It therefore pulses on every channel 1 event, even while `cc1_flag` is already set.
- R11: Source codes 100, 101, 110 and 111 make `trig_out` equal to `oc_ref[0]`, `oc_ref[1]`, `oc_ref[2]` and `oc_ref[3]` respectively, delayed one clock.
- R12: While `rst_n` is low, the counter, prescaler, flag, capture register, synchroniser and all pulse outputs and `trig_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cnt_en_bit | input | 1 | Software counter enable |
| gated_mode | input | 1 | Lets `ext_trig` also enable counting |
| ext_trig | input | 1 | External trigger input |
| upd_gen | input | 1 | Software update request |
| psc_div | input | PSC_W | Prescaler terminal value |
| arr | input | CNT_W | Counter reload value |
| cmp_val | input | 4*CNT_W | Compare values, channel k at bits k*CNT_W |
| ch1_capture | input | 1 | Channel 1 in capture mode |
| ti_xor_sel | input | 1 | Channel 1 input is XOR of three pins |
| ch_pin | input | 3 | Channel pins 1 to 3 |
| cc1_flag_clr | input | 1 | Clears the channel 1 flag |
| dma_on_upd | input | 1 | DMA requests follow the update event |
| trig_mode | input | 3 | Trigger source code |
| cnt_q | output | CNT_W | Counter value |
| upd_evt | output | 1 | Update event pulse |
| oc_ref | output | 4 | Compare reference waveforms |
| cc_evt | output | 4 | Channel event pulses |
| cc1_flag | output | 1 | Sticky channel 1 event flag |
| cc1_capt | output | CNT_W | Captured count |
| dma_req | output | 4 | DMA request pulses |
| trig_out | output | 1 | Trigger output |

## Verification
The bench keeps a cycle model of the timer and feeds it random configurations and pin activity. It adds directed cases for a compare value equal to zero or to the reload value. A design that checked the compare only at wrap-around would miss the match on the value 0 reached after an update request. A design that held the prescaler across the update request would step the counter early. Other directed cases cover gated counting with the software enable off, and a capture caused by toggling only the third pin in XOR mode. The bench also sends repeated channel 1 events while the flag stays set. A design that gated the pulse source with the flag would lose the second pulse on `trig_out`. A design that ignored a pin in the XOR would miss the capture.

// File: rtl/tmr_trig_pkg.sv
package tmr_trig_pkg;
   localparam int unsigned NUM_CH = 4;

   typedef enum logic [2:0] {
      TRG_UG   = 3'b000,
      TRG_RUN  = 3'b001,
      TRG_UPD  = 3'b010,
      TRG_CC1P = 3'b011,
      TRG_OC1  = 3'b100,
      TRG_OC2  = 3'b101,
      TRG_OC3  = 3'b110,
      TRG_OC4  = 3'b111
   } trg_src_e;
endpackage

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned PSC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             ug,
   input  logic [PSC_W-1:0] psc_div,
   input  logic [CNT_W-1:0] arr,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic             step,
   output logic             upd_nxt,
   output logic             upd_evt
);
   logic [PSC_W-1:0] psc_q, psc_nxt;

   // next-state of prescaler and counter; update request has priority
   always_comb begin
      step    = 1'b0;
      upd_nxt = 1'b0;
      cnt_nxt = cnt_q;
      psc_nxt = psc_q;
      if (ug) begin
         step    = 1'b1;
         upd_nxt = 1'b1;
         cnt_nxt = '0;
         psc_nxt = '0;
      end else if (run) begin
         if (psc_q == psc_div) begin
            psc_nxt = '0;
            step    = 1'b1;
            if (cnt_q == arr) begin
               cnt_nxt = '0;
               upd_nxt = 1'b1;
            end else begin
               cnt_nxt = cnt_q + 1'b1;
            end
         end else begin
            psc_nxt = psc_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psc_q   <= '0;
         cnt_q   <= '0;
         upd_evt <= 1'b0;
      end else begin
         psc_q   <= psc_nxt;
         cnt_q   <= cnt_nxt;
         upd_evt <= upd_nxt;
      end
   end
endmodule

// File: rtl/tmr_cc_chan.sv
module tmr_cc_chan #(
   parameter int unsigned CNT_W   = 16,
   parameter bit          CAPT_OK = 1'b0,
   parameter int unsigned SYNC_N  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_q,
   input  logic [CNT_W-1:0] cnt_nxt,
   input  logic             step,
   input  logic             upd_nxt,
   input  logic [CNT_W-1:0] cmp,
   input  logic             cap_mode,
   input  logic             ti,
   input  logic             dma_sel,
   output logic             oc_ref,
   output logic             evt_nxt,
   output logic             evt,
   output logic             dma_req,
   output logic [CNT_W-1:0] capt_q
);
   logic match_nxt;

   assign oc_ref    = (cnt_q < cmp);
   assign match_nxt = step && (cnt_nxt == cmp);

   generate
      if (CAPT_OK) begin : g_capt
         logic [SYNC_N-1:0] sync_q;
         logic              prev_q;
         logic              rise;

         assign rise    = sync_q[SYNC_N-1] & ~prev_q;
         assign evt_nxt = cap_mode ? rise : match_nxt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sync_q <= '0;
               prev_q <= 1'b0;
               capt_q <= '0;
            end else begin
               sync_q <= {sync_q[SYNC_N-2:0], ti};
               prev_q <= sync_q[SYNC_N-1];
               if (cap_mode && rise)
                  capt_q <= cnt_q;
            end
         end
      end else begin : g_cmp_only
         logic unused_capt_in;
         assign unused_capt_in = cap_mode ^ ti;
         assign evt_nxt        = match_nxt;
         assign capt_q         = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt     <= 1'b0;
         dma_req <= 1'b0;
      end else begin
         evt     <= evt_nxt;
         dma_req <= dma_sel ? upd_nxt : evt_nxt;
      end
   end
endmodule

// File: rtl/tmr_trig_mux.sv
module tmr_trig_mux
   import tmr_trig_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode,
   input  logic              ug,
   input  logic              run,
   input  logic              upd_nxt,
   input  logic              cc1_nxt,
   input  logic [NUM_CH-1:0] oc_ref,
   output logic              trig_out
);
   logic     sel;
   trg_src_e src;

   assign src = trg_src_e'(mode);

   always_comb begin
      unique case (src)
         TRG_UG:   sel = ug;
         TRG_RUN:  sel = run;
         TRG_UPD:  sel = upd_nxt;
         TRG_CC1P: sel = cc1_nxt;
         default:  sel = oc_ref[mode[1:0]];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trig_out <= 1'b0;
      else        trig_out <= sel;
   end
endmodule

// File: rtl/tmr_trig_gen.sv
module tmr_trig_gen
   import tmr_trig_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned PSC_W  = 8,
   parameter int unsigned SYNC_N = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cnt_en_bit,
   input  logic                    gated_mode,
   input  logic                    ext_trig,
   input  logic                    upd_gen,
   input  logic [PSC_W-1:0]        psc_div,
   input  logic [CNT_W-1:0]        arr,
   input  logic [NUM_CH*CNT_W-1:0] cmp_val,
   input  logic                    ch1_capture,
   input  logic                    ti_xor_sel,
   input  logic [2:0]              ch_pin,
   input  logic                    cc1_flag_clr,
   input  logic                    dma_on_upd,
   input  logic [2:0]              trig_mode,
   output logic [CNT_W-1:0]        cnt_q,
   output logic                    upd_evt,
   output logic [NUM_CH-1:0]       oc_ref,
   output logic [NUM_CH-1:0]       cc_evt,
   output logic                    cc1_flag,
   output logic [CNT_W-1:0]        cc1_capt,
   output logic [NUM_CH-1:0]       dma_req,
   output logic                    trig_out
);
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
         $error("tmr_trig_gen: CNT_W must be 2..32");
      end
      if (PSC_W < 1 || PSC_W > 32) begin : g_bad_psc_w
         $error("tmr_trig_gen: PSC_W must be 1..32");
      end
      if (SYNC_N < 2 || SYNC_N > 4) begin : g_bad_sync
         $error("tmr_trig_gen: SYNC_N must be 2..4");
      end
   endgenerate

   logic              run;
   logic              ti1;
   logic              step;
   logic              upd_nxt;
   logic [CNT_W-1:0]  cnt_nxt;
   logic [NUM_CH-1:0] evt_nxt;
   logic [CNT_W-1:0]  capt_w [NUM_CH];

   assign run = cnt_en_bit | (gated_mode & ext_trig);
   assign ti1 = ti_xor_sel ? ^ch_pin : ch_pin[0];

   tmr_count_core #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .ug      (upd_gen),
      .psc_div (psc_div),
      .arr     (arr),
      .cnt_q   (cnt_q),
      .cnt_nxt (cnt_nxt),
      .step    (step),
      .upd_nxt (upd_nxt),
      .upd_evt (upd_evt)
   );

   generate
      for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
         tmr_cc_chan #(
            .CNT_W   (CNT_W),
            .CAPT_OK (k == 0),
            .SYNC_N  (SYNC_N)
         ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt_q    (cnt_q),
            .cnt_nxt  (cnt_nxt),
            .step     (step),
            .upd_nxt  (upd_nxt),
            .cmp      (cmp_val[k*CNT_W +: CNT_W]),
            .cap_mode (ch1_capture),
            .ti       (ti1),
            .dma_sel  (dma_on_upd),
            .oc_ref   (oc_ref[k]),
            .evt_nxt  (evt_nxt[k]),
            .evt      (cc_evt[k]),
            .dma_req  (dma_req[k]),
            .capt_q   (capt_w[k])
         );
      end
   endgenerate

   assign cc1_capt = capt_w[0];

   logic unused_capt;
   assign unused_capt = ^{capt_w[1], capt_w[2], capt_w[3]};

   // sticky flag; a new event wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cc1_flag <= 1'b0;
      else        cc1_flag <= (cc1_flag & ~cc1_flag_clr) | evt_nxt[0];
   end

   tmr_trig_mux u_mux (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (trig_mode),
      .ug       (upd_gen),
      .run      (run),
      .upd_nxt  (upd_nxt),
      .cc1_nxt  (evt_nxt[0]),
      .oc_ref   (oc_ref),
      .trig_out (trig_out)
   );
endmodule

// File: rtl/tmr_trig_gen_chk.sv
module tmr_trig_gen_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cnt_en_bit,
   input logic             gated_mode,
   input logic             ext_trig,
   input logic             upd_gen,
   input logic [2:0]       trig_mode,
   input logic             dma_on_upd,
   input logic [CNT_W-1:0] cnt_q,
   input logic             upd_evt,
   input logic [3:0]       oc_ref,
   input logic [3:0]       cc_evt,
   input logic             cc1_flag,
   input logic [3:0]       dma_req,
   input logic             trig_out
);
   // R1: the counter only ever steps by one or returns to zero
   a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != $past(cnt_q)) |-> (cnt_q == '0 || cnt_q == $past(cnt_q) + 1'b1));

   // R2: an update request clears the count and gives an update pulse
   a_r2_ug_clears: assert property (@(posedge clk) disable iff (!rst_n)
      upd_gen |=> (upd_evt && cnt_q == '0));

   // R3: no enable and no update request means the count holds
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!(cnt_en_bit | (gated_mode & ext_trig)) && !upd_gen) |=> $stable(cnt_q));

   // R5: the flag is high whenever a channel 1 event is present
   a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      cc_evt[0] |-> cc1_flag);

   // R8: update-timed DMA requests mirror the update pulse
   a_r8_dma_upd: assert property (@(posedge clk) disable iff (!rst_n)
      dma_on_upd |=> (dma_req == {4{upd_evt}}));

   // R9: source 000 passes the update request one clock later
   a_r9_src_ug: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_mode == 3'b000) |=> (trig_out == $past(upd_gen)));

   // R10: source 011 copies the channel 1 event pulse
   a_r10_src_cc1: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_mode == 3'b011) |=> (trig_out == cc_evt[0]));

   // R11: source 100 passes the channel 1 reference one clock later
   a_r11_src_oc1: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_mode == 3'b100) |=> (trig_out == $past(oc_ref[0])));
endmodule

bind tmr_trig_gen tmr_trig_gen_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cnt_en_bit (cnt_en_bit),
   .gated_mode (gated_mode),
   .ext_trig   (ext_trig),
   .upd_gen    (upd_gen),
   .trig_mode  (trig_mode),
   .dma_on_upd (dma_on_upd),
   .cnt_q      (cnt_q),
   .upd_evt    (upd_evt),
   .oc_ref     (oc_ref),
   .cc_evt     (cc_evt),
   .cc1_flag   (cc1_flag),
   .dma_req    (dma_req),
   .trig_out   (trig_out)
);

// File: tb/test_tmr_trig_gen.sv
module test_tmr_trig_gen;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 16;
   localparam int PW = 8;
   localparam int SN = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cen = 0, gated = 0, ext = 0, ug = 0;
   logic [PW-1:0] psc = '0;
   logic [CW-1:0] arr = '0;
   logic [CW-1:0] cmp [4];
   logic          capm = 0, xsel = 0, fclr = 0, dsel = 0;
   logic [2:0]    pins = '0, mode = '0;

   logic [CW-1:0] cnt_q, capt;
   logic          upd_evt, flag, trig;
   logic [3:0]    oc_ref, cc_evt, dma;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tmr_trig_gen #(.CNT_W(CW), .PSC_W(PW), .SYNC_N(SN)) i_tmr_trig_gen (
      .clk(clk), .rst_n(rst_n), .cnt_en_bit(cen), .gated_mode(gated), .ext_trig(ext),
      .upd_gen(ug), .psc_div(psc), .arr(arr),
      .cmp_val({cmp[3], cmp[2], cmp[1], cmp[0]}),
      .ch1_capture(capm), .ti_xor_sel(xsel), .ch_pin(pins), .cc1_flag_clr(fclr),
      .dma_on_upd(dsel), .trig_mode(mode), .cnt_q(cnt_q), .upd_evt(upd_evt),
      .oc_ref(oc_ref), .cc_evt(cc_evt), .cc1_flag(flag), .cc1_capt(capt),
      .dma_req(dma), .trig_out(trig)
   );

   // reference model state
   logic [PW-1:0] m_psc = '0;
   logic [CW-1:0] m_cnt = '0, m_capt = '0;
   logic          m_upd = 0, m_flag = 0, m_trig = 0, m_prev = 0;
   logic [3:0]    m_evt = '0, m_dma = '0;
   logic [SN-1:0] m_sync = '0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic m_run();
      return cen | (gated & ext);
   endfunction

   function automatic logic m_ti();
      return xsel ? (pins[0] ^ pins[1] ^ pins[2]) : pins[0];
   endfunction

   function automatic string trig_req(input logic [2:0] md);
      if (md <= 3'd2) return "R9";
      if (md == 3'd3) return "R10";
      return "R11";
   endfunction

   // advance the model by one clock using the inputs now applied
   task automatic model_step();
      logic          step = 0, upd_n = 0, rise;
      logic [CW-1:0] cnt_n = m_cnt;
      logic [PW-1:0] psc_n = m_psc;
      logic [3:0]    evt_n, oc;
      logic          tsel;
      if (ug) begin
         step = 1; upd_n = 1; cnt_n = '0; psc_n = '0;
      end else if (m_run()) begin
         if (m_psc == psc) begin
            psc_n = '0; step = 1;
            if (m_cnt == arr) begin cnt_n = '0; upd_n = 1; end
            else cnt_n = m_cnt + 16'd1;
         end else psc_n = m_psc + 8'd1;
      end
      for (int k = 0; k < 4; k++) begin
         oc[k]    = (m_cnt < cmp[k]);
         evt_n[k] = step && (cnt_n == cmp[k]);
      end
      rise = m_sync[SN-1] & ~m_prev;
      if (capm) begin
         evt_n[0] = rise;
         if (rise) m_capt = m_cnt;
      end
      case (mode)
         3'd0: tsel = ug;
         3'd1: tsel = m_run();
         3'd2: tsel = upd_n;
         3'd3: tsel = evt_n[0];
         default: tsel = oc[mode[1:0]];
      endcase
      m_flag = (m_flag & ~fclr) | evt_n[0];
      m_dma  = dsel ? {4{upd_n}} : evt_n;
      m_prev = m_sync[SN-1];
      m_sync = {m_sync[SN-2:0], m_ti()};
      m_psc  = psc_n;
      m_cnt  = cnt_n;
      m_upd  = upd_n;
      m_evt  = evt_n;
      m_trig = tsel;
   endtask

   task automatic compare_all();
      logic [2:0] pmode = mode;
      chk(cnt_q == m_cnt, "R1", "cnt_q", cnt_q, m_cnt);
      chk(upd_evt == m_upd, ug ? "R2" : "R1", "upd_evt", upd_evt, m_upd);
      for (int k = 0; k < 4; k++)
         chk(oc_ref[k] == (m_cnt < cmp[k]), "R4", "oc_ref", oc_ref[k], m_cnt < cmp[k]);
      chk(cc_evt == m_evt, capm ? "R6" : "R5", "cc_evt", cc_evt, m_evt);
      chk(flag == m_flag, "R5", "cc1_flag", flag, m_flag);
      chk(capt == m_capt, "R6", "cc1_capt", capt, m_capt);
      chk(dma == m_dma, "R8", "dma_req", dma, m_dma);
      chk(trig == m_trig, trig_req(pmode), "trig_out", trig, m_trig);
   endtask

   // one clock: model steps with the held inputs, outputs compared after the edge
   logic [2:0] last_mode;
   task automatic tick();
      last_mode = mode;
      model_step();
      @(posedge clk);
      @(negedge clk);
      chk(trig == m_trig, trig_req(last_mode), "trig_out", trig, m_trig);
      chk(cnt_q == m_cnt, "R1", "cnt_q", cnt_q, m_cnt);
      chk(upd_evt == m_upd, "R2", "upd_evt", upd_evt, m_upd);
      for (int k = 0; k < 4; k++)
         chk(oc_ref[k] == (m_cnt < cmp[k]), "R4", "oc_ref", oc_ref[k], m_cnt < cmp[k]);
      chk(cc_evt == m_evt, capm ? "R6" : "R5", "cc_evt", cc_evt, m_evt);
      chk(flag == m_flag, "R5", "cc1_flag", flag, m_flag);
      chk(capt == m_capt, "R6", "cc1_capt", capt, m_capt);
      chk(dma == m_dma, "R8", "dma_req", dma, m_dma);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [CW-1:0] held;
      void'($urandom(32'd1234));
      for (int k = 0; k < 4; k++) cmp[k] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R12: reset state
      chk(cnt_q == 0 && upd_evt == 0 && cc_evt == 0 && dma == 0, "R12", "pulses/count",
          {cnt_q, upd_evt, cc_evt, dma}, 0);
      chk(flag == 0 && trig == 0 && capt == 0, "R12", "flag/trig/capt", {flag, trig, capt}, 0);
      rst_n = 1;

      // directed: compare at 0 and at arr, update request mid-count
      arr = 16'd5; psc = 8'd1; cmp[0] = 16'd0; cmp[1] = 16'd5; cmp[2] = 16'd3; cmp[3] = 16'd6;
      cen = 1; mode = 3'd2;
      repeat (20) tick();
      ug = 1; tick(); ug = 0;
      repeat (6) tick();

      // R3: gated counting with software enable off
      cen = 0; gated = 1; ext = 0;
      held = cnt_q;
      repeat (5) tick();
      chk(cnt_q == held, "R3", "held count", cnt_q, held);
      ext = 1; mode = 3'd1;
      repeat (8) tick();
      gated = 0;
      repeat (3) tick();
      chk(trig == 1'b0, "R3", "run enable on trig", trig, 0);

      // R10: repeated channel 1 events with flag left set
      cen = 1; mode = 3'd3; psc = 8'd0; cmp[0] = 16'd2;
      repeat (20) tick();
      chk(flag == 1'b1, "R10", "flag still set", flag, 1);

      // R7/R6: capture via third pin only in XOR mode, counter stopped
      cen = 0; capm = 1; xsel = 1; pins = 3'b000;
      repeat (4) tick();
      pins = 3'b100;
      repeat (SN) tick();
      chk(cc_evt[0] == 1'b0, "R6", "early capture", cc_evt[0], 0);
      tick();
      chk(cc_evt[0] == 1'b1, "R7", "xor capture", cc_evt[0], 1);
      chk(capt == cnt_q, "R6", "captured count", capt, cnt_q);
      xsel = 0;
      pins = 3'b000; repeat (3) tick();
      pins = 3'b110; repeat (SN + 2) tick();
      chk(cc_evt[0] == 1'b0, "R7", "pins 2/3 ignored", cc_evt[0], 0);
      capm = 0;

      // constrained random
      for (int blk = 0; blk < 60; blk++) begin
         arr  = CW'($urandom_range(1, 9));
         psc  = PW'($urandom_range(0, 2));
         for (int k = 0; k < 4; k++) cmp[k] = CW'($urandom_range(0, 10));
         mode = 3'($urandom_range(0, 7));
         dsel = 1'($urandom_range(0, 1));
         capm = 1'($urandom_range(0, 1));
         xsel = 1'($urandom_range(0, 1));
         gated = 1'($urandom_range(0, 1));
         for (int c = 0; c < 60; c++) begin
            cen  = ($urandom_range(0, 9) != 0);
            ext  = 1'($urandom_range(0, 1));
            ug   = ($urandom_range(0, 24) == 0);
            fclr = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 3) == 0) pins = 3'($urandom_range(0, 7));
            tick();
         end
         ug = 0; fclr = 0;
      end
      finish_run();
   end
endmodule